// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative store of lines that a direct-mapped main cache has thrown out. It sits on the main cache's refill path. When the main cache misses, it presents the missing line address here before anything goes to memory. The same request also carries the line that the main cache is about to displace, if there is one. Every entry is compared against the address in parallel during the same cycle.

On a hit, the buffer returns the stored line and its dirty state in that cycle, and no memory request is raised. At the next clock edge the main cache's outgoing line moves into the slot that the returned line leaves, so the two lines trade places. On a miss, the address is passed on to memory in that cycle. The outgoing line goes into a free slot if one exists. Otherwise it takes the place of the entry that was inserted longest ago. That entry is sent to memory as a write only if it is dirty. Lines fetched from memory never enter the buffer.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses.
- R2: A lookup whose address matches a valid entry raises `hit` in the same cycle and returns that entry's data on `hit_data` and its dirty flag on `hit_dirty`. `mem_req_valid` stays low.
- R3: A lookup that matches no entry raises `mem_req_valid` in the same cycle, with `mem_req_addr` equal to the lookup address. `hit` stays low.
- R4: On a hit with an outgoing line present, that line, with its address, data and dirty flag, replaces the hit entry at the clock edge. Afterwards the outgoing line is found and the returned line is not.
- R5: On a hit with no outgoing line, the hit entry becomes invalid at the clock edge.
- R6: On a miss with an outgoing line while some entry is invalid, the line fills the lowest-numbered invalid entry and nothing is displaced.
- R7: On a miss with an outgoing line while all entries are valid, the entry inserted longest ago is displaced. Both a swap and a fill count as an insertion of the incoming line.
- R8: When a displaced entry is dirty, `wb_valid` rises in that same cycle with the entry's address and data. A clean displaced entry produces no write.
- R9: An outgoing line presented without a lookup is ignored, and the stored contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Main-cache miss lookup request |
| lookup_addr | input | ADDR_W | Line address being looked up |
| victim_valid | input | 1 | Main cache supplies an outgoing line |
| victim_addr | input | ADDR_W | Outgoing line address |
| victim_dirty | input | 1 | Outgoing line is modified |
| victim_data | input | DATA_W | Outgoing line data |
| hit | output | 1 | Lookup found in buffer |
| hit_data | output | DATA_W | Data of the found line |
| hit_dirty | output | 1 | Dirty flag of the found line |
| mem_req_valid | output | 1 | Request forwarded to memory |
| mem_req_addr | output | ADDR_W | Forwarded line address |
| wb_valid | output | 1 | Dirty displaced line written to memory |
| wb_addr | output | ADDR_W | Address of written-back line |
| wb_data | output | DATA_W | Data of written-back line |

## Verification
If an entry's address, data or dirty flag is stored wrongly, the fault shows up at the very next lookup of that line. It appears as a false miss, as wrong `hit_data` or `hit_dirty`, or as a write-back carrying the wrong address or data. A fault in the insertion-age bookkeeping stays hidden until the buffer is full and a miss brings in a new line. At that point the wrong line is displaced, which shows as an unexpected or missing `wb_valid` or as a later false hit. The stimulus therefore fills the buffer and then runs several displacements after swaps and removals, so that the age order is exposed within a few lookups.

// File: rtl/vb_pkg.sv
package vb_pkg;

    // Operation performed on the buffer in one cycle
    typedef enum logic [2:0] {
        VB_IDLE,     // no lookup
        VB_SWAP,     // hit, outgoing line takes the hit slot
        VB_DROP,     // hit, no outgoing line: slot released
        VB_FORWARD,  // miss, no outgoing line
        VB_FILL,     // miss, outgoing line goes to a free slot
        VB_REPLACE   // miss, outgoing line displaces the oldest entry
    } vb_op_e;

    function automatic vb_op_e vb_decode(input logic lookup, input logic found,
                                         input logic incoming, input logic full);
        if (!lookup)         return VB_IDLE;
        if (found)           return incoming ? VB_SWAP : VB_DROP;
        if (!incoming)       return VB_FORWARD;
        return full ? VB_REPLACE : VB_FILL;
    endfunction

endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 16,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0]             ent_valid,
    input  logic [N_ENT-1:0][ADDR_W-1:0] ent_tag,
    input  logic [ADDR_W-1:0]            key,
    output logic [N_ENT-1:0]             match,
    output logic                         any_match,
    output logic [IDX_W-1:0]             match_idx
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_tag[g] == key);
    end

    assign any_match = |match;

    always_comb begin
        match_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (match[i]) match_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/vb_age.sv
module vb_age #(
    parameter int N_ENT = 4,   // power of two
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_ENT-1:0] ent_valid,
    input  logic             ins,      // a line is written into slot
    input  logic             kill,     // slot is released
    input  logic [IDX_W-1:0] slot,
    output logic             full,
    output logic [IDX_W-1:0] victim
);
    logic [N_ENT-1:0][IDX_W-1:0] age_q;
    logic [N_ENT-1:0]            oldest;
    logic                        free_found;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                if (ins) begin
                    if (IDX_W'(i) == slot)
                        age_q[i] <= '0;
                    else if (ent_valid[i] && (!ent_valid[slot] || age_q[i] < age_q[slot]))
                        age_q[i] <= age_q[i] + 1'b1;
                end else if (kill) begin
                    if (ent_valid[i] && age_q[i] > age_q[slot])
                        age_q[i] <= age_q[i] - 1'b1;
                end
            end
        end
    end

    assign full = &ent_valid;

    for (genvar g = 0; g < N_ENT; g++) begin : g_old
        assign oldest[g] = ent_valid[g] && (age_q[g] == IDX_W'(N_ENT - 1));
    end

    always_comb begin
        victim     = '0;
        free_found = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (!ent_valid[i] && !free_found) begin
                victim     = IDX_W'(i);
                free_found = 1'b1;
            end
        end
        if (full) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (oldest[i]) victim = IDX_W'(i);
            end
        end
    end

    // R7: when all entries are valid exactly one of them is the oldest
    a_r7_single_oldest: assert property (@(posedge clk) disable iff (rst)
        full |-> $countones(oldest) == 1);
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lookup_valid,
    input  logic [ADDR_W-1:0] lookup_addr,
    input  logic              victim_valid,
    input  logic [ADDR_W-1:0] victim_addr,
    input  logic              victim_dirty,
    input  logic [DATA_W-1:0] victim_data,
    output logic              hit,
    output logic [DATA_W-1:0] hit_data,
    output logic              hit_dirty,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);
    import vb_pkg::*;

    logic [N_ENT-1:0]             valid_q, dirty_q;
    logic [N_ENT-1:0][ADDR_W-1:0] tag_q;
    logic [N_ENT-1:0][DATA_W-1:0] data_q;

    logic [N_ENT-1:0] match;
    logic             any_match, full;
    logic [IDX_W-1:0] hit_idx, sel_idx, upd_idx;
    vb_op_e           op;

    vb_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_match (
        .ent_valid(valid_q), .ent_tag(tag_q), .key(lookup_addr),
        .match(match), .any_match(any_match), .match_idx(hit_idx)
    );

    assign op      = vb_decode(lookup_valid, any_match, victim_valid, full);
    assign upd_idx = (op == VB_SWAP || op == VB_DROP) ? hit_idx : sel_idx;

    vb_age #(.N_ENT(N_ENT)) u_age (
        .clk(clk), .rst(rst), .ent_valid(valid_q),
        .ins(op == VB_SWAP || op == VB_FILL || op == VB_REPLACE),
        .kill(op == VB_DROP), .slot(upd_idx),
        .full(full), .victim(sel_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            unique case (op)
                VB_SWAP, VB_FILL, VB_REPLACE: begin
                    valid_q[upd_idx] <= 1'b1;
                    dirty_q[upd_idx] <= victim_dirty;
                    tag_q[upd_idx]   <= victim_addr;
                    data_q[upd_idx]  <= victim_data;
                end
                VB_DROP: valid_q[upd_idx] <= 1'b0;
                default: ;
            endcase
        end
    end

    assign hit           = lookup_valid && any_match;
    assign hit_data      = data_q[hit_idx];
    assign hit_dirty     = dirty_q[hit_idx];
    assign mem_req_valid = lookup_valid && !any_match;
    assign mem_req_addr  = lookup_addr;
    assign wb_valid      = (op == VB_REPLACE) && dirty_q[sel_idx];
    assign wb_addr       = tag_q[sel_idx];
    assign wb_data       = data_q[sel_idx];

    // R1: reset empties the buffer
    a_r1_reset_empty: assert property (@(posedge clk)
        rst |=> valid_q == '0);
    // R2: an address is held by at most one entry
    a_r2_unique_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));
    // R5: a hit with no outgoing line removes one entry
    a_r5_drop_shrinks: assert property (@(posedge clk) disable iff (rst)
        (hit && !victim_valid) |=> $countones(valid_q) == $countones($past(valid_q)) - 1);
    // R6: a miss with an outgoing line and a free slot adds one entry
    a_r6_fill_grows: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && victim_valid && !(&valid_q)) |=>
            $countones(valid_q) == $countones($past(valid_q)) + 1);
    // R8: a write-back only occurs from a full buffer
    a_r8_wb_when_full: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (&valid_q && mem_req_valid));
    // R9: no lookup leaves the contents untouched
    a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst)
        !lookup_valid |=> ($stable(valid_q) && $stable(tag_q) && $stable(dirty_q)));
endmodule

// File: tb/victim_buffer_tb_top.sv
module victim_buffer_tb_top;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          lookup_valid, victim_valid, victim_dirty;
    logic [AW-1:0] lookup_addr, victim_addr;
    logic [DW-1:0] victim_data;
    logic          hit, hit_dirty, mem_req_valid, wb_valid;
    logic [DW-1:0] hit_data, wb_data;
    logic [AW-1:0] mem_req_addr, wb_addr;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    victim_buffer #(.N_ENT(4), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .lookup_valid(lookup_valid), .lookup_addr(lookup_addr),
        .victim_valid(victim_valid), .victim_addr(victim_addr),
        .victim_dirty(victim_dirty), .victim_data(victim_data),
        .hit(hit), .hit_data(hit_data), .hit_dirty(hit_dirty),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    function automatic logic [DW-1:0] line_of(input logic [AW-1:0] a);
        return {a ^ 16'hA5A5, a};
    endfunction

    typedef struct packed {
        logic [3:0]    rq;      // requirement focus
        logic          lk;
        logic [AW-1:0] la;
        logic          vv;
        logic [AW-1:0] va;
        logic          vd;
        logic          eh;      // expected hit
        logic          ehd;     // expected hit dirty
        logic          ewb;     // expected write-back
        logic [AW-1:0] ewa;     // expected write-back address
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{4'd6, 1'b1, 16'd10,  1'b1, 16'd100, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},
        '{4'd6, 1'b1, 16'd11,  1'b1, 16'd101, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},
        '{4'd6, 1'b1, 16'd12,  1'b1, 16'd102, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},
        '{4'd6, 1'b1, 16'd13,  1'b1, 16'd103, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},
        '{4'd4, 1'b1, 16'd101, 1'b1, 16'd200, 1'b0, 1'b1, 1'b1, 1'b0, 16'd0},  // swap
        '{4'd7, 1'b1, 16'd20,  1'b1, 16'd201, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},  // 100 out, clean
        '{4'd7, 1'b1, 16'd21,  1'b1, 16'd202, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},  // 102 out, clean
        '{4'd8, 1'b1, 16'd22,  1'b1, 16'd203, 1'b0, 1'b0, 1'b0, 1'b1, 16'd103},
        '{4'd5, 1'b1, 16'd200, 1'b0, 16'd0,   1'b0, 1'b1, 1'b0, 1'b0, 16'd0},  // drop
        '{4'd5, 1'b1, 16'd100, 1'b1, 16'd204, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},  // fills freed slot
        '{4'd9, 1'b0, 16'd0,   1'b1, 16'd300, 1'b1, 1'b0, 1'b0, 1'b0, 16'd0},  // ignored
        '{4'd9, 1'b1, 16'd300, 1'b0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b0, 16'd0},
        '{4'd4, 1'b1, 16'd202, 1'b1, 16'd205, 1'b0, 1'b1, 1'b1, 1'b0, 16'd0},  // swap renews
        '{4'd7, 1'b1, 16'd23,  1'b1, 16'd206, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},  // 201 out
        '{4'd7, 1'b1, 16'd24,  1'b1, 16'd207, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0},  // 203 out
        '{4'd8, 1'b1, 16'd25,  1'b1, 16'd208, 1'b0, 1'b0, 1'b0, 1'b1, 16'd204},
        '{4'd4, 1'b1, 16'd205, 1'b0, 16'd0,   1'b0, 1'b1, 1'b0, 1'b0, 16'd0}
    };

    function automatic string rq_name(input logic [3:0] r);
        case (r)
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic lk, input logic [AW-1:0] la, input logic vv,
                         input logic [AW-1:0] va, input logic vd);
        lookup_valid = lk;  lookup_addr = la;
        victim_valid = vv;  victim_addr = va;
        victim_dirty = vd;  victim_data = line_of(va);
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, '0, 1'b0, '0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: empty after reset
        drive(1'b1, 16'd10, 1'b0, '0, 1'b0);
        #5;
        check("R1", "hit after reset", DW'(hit), 0);
        check("R1 R3", "mem_req_valid", DW'(mem_req_valid), 1);
        check("R3", "mem_req_addr", DW'(mem_req_addr), 10);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VEC[k].lk, VEC[k].la, VEC[k].vv, VEC[k].va, VEC[k].vd);
            #5;
            check({rq_name(VEC[k].rq), " R2"}, $sformatf("v%0d hit", k), DW'(hit), DW'(VEC[k].eh));
            if (VEC[k].eh) begin
                check({rq_name(VEC[k].rq), " R2"}, $sformatf("v%0d hit_data", k),
                      hit_data, line_of(VEC[k].la));
                check({rq_name(VEC[k].rq), " R2"}, $sformatf("v%0d hit_dirty", k),
                      DW'(hit_dirty), DW'(VEC[k].ehd));
            end
            check({rq_name(VEC[k].rq), " R3"}, $sformatf("v%0d mem_req_valid", k),
                  DW'(mem_req_valid), DW'(VEC[k].lk && !VEC[k].eh));
            if (VEC[k].lk && !VEC[k].eh)
                check("R3", $sformatf("v%0d mem_req_addr", k), DW'(mem_req_addr), DW'(VEC[k].la));
            check({rq_name(VEC[k].rq), " R8"}, $sformatf("v%0d wb_valid", k),
                  DW'(wb_valid), DW'(VEC[k].ewb));
            if (VEC[k].ewb) begin
                check("R8", $sformatf("v%0d wb_addr", k), DW'(wb_addr), DW'(VEC[k].ewa));
                check("R8", $sformatf("v%0d wb_data", k), wb_data, line_of(VEC[k].ewa));
            end
        end

        // R1: reset in mid-run clears stored lines
        @(negedge clk);
        drive(1'b0, '0, 1'b0, '0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b1, 16'd208, 1'b0, '0, 1'b0);
        #5;
        check("R1", "hit after second reset", DW'(hit), 0);
        check("R1", "mem_req after second reset", DW'(mem_req_valid), 1);

        @(negedge clk);
        drive(1'b0, '0, 1'b0, '0, 1'b0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #2000000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule